// File: doc/BRIEF.md
# Tamper Security Supervisor

This block sits beside a battery-backed timekeeping unit and decides whether that unit can be trusted. Two status flags encode its condition. With both clear the unit is valid. The non-valid flag alone is set after battery power returns. The violation flag alone marks failure. Both together mark the recoverable non-valid+failure condition that a system reset produces from failure.

Ten event sources can push the unit into failure. These are eight physical tamper sensors plus the time-counter and monotonic-counter overflows. Each source is accepted only while its enable bit is set. An accepted event latches a detect bit and raises the violation flag.

The block also keeps a set of lock bits. Soft locks fall on a system reset. Hard locks fall only on a battery reset. The locks gate writes to the enable register and to the time counter. Software recovers from failure in a fixed order: disable the sources, clear the detect bits, clear the violation flag, and clear the non-valid flag last.

Top module: `tamper_sup_top`

## Requirements
- R1: While `batRstN` is low at a clock edge, the next state has the non-valid flag (status bit 1) set and every other bit of the status, control and enable words clear. The interrupt enable is also cleared.
- R2: Source i sets a detect bit at the next edge only while it is high and enable bit i (enable word bit i) is set. That edge also sets the violation flag (status bit 0). The detect bit is status bit 16+i for i = 0..7, bit 2 for i = 8 (time overflow) and bit 3 for i = 9 (monotonic overflow). A source whose enable is clear changes nothing.
- R3: `freezeTime` is high whenever either status flag is set, and low only in the valid state.
- R4: `secIrq` is high exactly when the violation flag is set and the interrupt enable is set. The interrupt enable is bit 0 of address 3.
- R5: In failure alone (violation set, non-valid clear), a write to the status word at address 1 is ignored. A system reset in that state sets the non-valid flag and keeps the detect bits and the violation flag.
- R6: A write to the enable word at address 2 is refused while control bit 30 (tamper hard lock) or control bit 29 (tamper soft lock) is set.
- R7: Writes to the control word at address 0 can only set lock bits. The hard locks are bits 30, 20, 18 and 16, and only a battery reset clears them. The soft locks are bits 29, 19 and 17, and a system reset clears them.
- R8: Writing 1 to a detect bit clears it, unless its source is still high and enabled in that cycle. In that case the bit stays set.
- R9: Writing 1 to status bit 0 clears the violation flag only when the non-valid flag is set and no detect bit is set. Otherwise the write is ignored.
- R10: Writing 1 to status bit 1 clears the non-valid flag only while the violation flag is clear.
- R11: `timeWrAllow` is low while control bit 17 (timer soft lock) or bit 18 (timer hard lock) is set, and high otherwise.
- R12: A system reset clears the interrupt enable. It leaves the status flags unchanged unless the unit is in failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| batRstN | input | 1 | Battery power-on reset, active low, synchronous |
| sysRstN | input | 1 | System reset, active low, synchronous |
| tamperIn | input | 10 | Event sources, index order as in R2 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 control, 1 status, 2 enable, 3 interrupt enable |
| wrData | input | 32 | Write data |
| statusWord | output | 32 | Status flags and detect bits |
| ctrlWord | output | 32 | Lock bits |
| cfgWord | output | 32 | Source enables in bits 9:0 |
| secIrq | output | 1 | Violation interrupt |
| freezeTime | output | 1 | Stops the time counters |
| timeWrAllow | output | 1 | Time counter may be written |

## Verification
The bench goes after the order of the recovery steps. It tries to clear the violation flag while detect bits remain, and it tries to clear the non-valid flag before the violation flag. A design that accepted either write would report valid while evidence of the tamper still stood. The bench holds a source active during a detect-clear to catch a design whose clear overrides a live event. It also fires all ten sources at once to check each bit position. It checks the lock behaviour across both reset types. A design that cleared hard locks on a system reset, or let a write drop a lock, would leave the enable word open to change after a violation.

// File: rtl/tamper_sup_pkg.sv
package tamper_sup_pkg;
  localparam int NUM_SRC = 10;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN = 2'd3;

  localparam int BIT_VIOL    = 0;
  localparam int BIT_NV      = 1;
  localparam int BIT_TC_SOFT = 17;
  localparam int BIT_TC_HARD = 18;
  localparam int BIT_TL_SOFT = 29;
  localparam int BIT_TL_HARD = 30;

  localparam logic [REG_W-1:0] HARD_MASK = 32'h4015_0000;
  localparam logic [REG_W-1:0] SOFT_MASK = 32'h200A_0000;

  // status bit holding the detect latch of source idx
  function automatic int detPos(input int idx);
    return (idx < 8) ? (16 + idx) : (idx - 6);
  endfunction

  typedef struct packed {
    logic batRst;
    logic sysRst;
    logic wrCtrl;
    logic wrCfg;
    logic wrStat;
    logic wrIrqEn;
    logic clrViol;
    logic clrNv;
  } strobe_t;
endpackage

// File: rtl/tamper_sup_ctrl.sv
module tamper_sup_ctrl
  import tamper_sup_pkg::*;
(
  input  logic              batRstN,
  input  logic              sysRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrFlags,
  input  logic              violation,
  input  logic              nonValid,
  input  logic              anyDet,
  input  logic              cfgLocked,
  output strobe_t           stb
);
  logic busOk;
  logic failOnly;

  always_comb begin
    busOk    = wrEn && batRstN && sysRstN;
    failOnly = violation && !nonValid;

    stb         = '0;
    stb.batRst  = !batRstN;
    stb.sysRst  = batRstN && !sysRstN;
    stb.wrCtrl  = busOk && (wrAddr == ADDR_CTRL);
    stb.wrCfg   = busOk && (wrAddr == ADDR_CFG) && !cfgLocked;
    stb.wrIrqEn = busOk && (wrAddr == ADDR_IRQEN);
    // failure alone: software cannot touch the status word
    stb.wrStat  = busOk && (wrAddr == ADDR_STAT) && !failOnly;
    // violation clears only from non-valid with no evidence left
    stb.clrViol = stb.wrStat && wrFlags[BIT_VIOL] && nonValid && !anyDet;
    // non-valid clears last, once the violation is gone
    stb.clrNv   = stb.wrStat && wrFlags[BIT_NV] && !violation;
  end
endmodule

// File: rtl/tamper_sup_dpath.sv
module tamper_sup_dpath
  import tamper_sup_pkg::*;
(
  input  logic               clk,
  input  strobe_t            stb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] tamperIn,
  output logic               violation,
  output logic               nonValid,
  output logic [NUM_SRC-1:0] det,
  output logic [NUM_SRC-1:0] srcEn,
  output logic [REG_W-1:0]   lockWord,
  output logic               irqEn
);
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] clrMask;
  logic [REG_W-1:0]   hardLk;
  logic [REG_W-1:0]   softLk;

  assign hit = tamperIn & srcEn;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    assign clrMask[g] = stb.wrStat && wrData[detPos(g)];
  end

  always_ff @(posedge clk) begin
    if (stb.batRst) begin
      violation <= 1'b0;
      nonValid  <= 1'b1;
      det       <= '0;
      srcEn     <= '0;
      hardLk    <= '0;
      softLk    <= '0;
      irqEn     <= 1'b0;
    end else begin
      det <= (det & ~clrMask) | hit;

      if (|hit)             violation <= 1'b1;
      else if (stb.clrViol) violation <= 1'b0;

      if (stb.sysRst && violation) nonValid <= 1'b1;
      else if (stb.clrNv)          nonValid <= 1'b0;

      if (stb.wrCfg) srcEn <= wrData[NUM_SRC-1:0];

      if (stb.wrCtrl) hardLk <= hardLk | (wrData & HARD_MASK);

      if (stb.sysRst)      softLk <= '0;
      else if (stb.wrCtrl) softLk <= softLk | (wrData & SOFT_MASK);

      if (stb.sysRst)       irqEn <= 1'b0;
      else if (stb.wrIrqEn) irqEn <= wrData[0];
    end
  end

  assign lockWord = hardLk | softLk;
endmodule

// File: rtl/tamper_sup_top.sv
module tamper_sup_top
  import tamper_sup_pkg::*;
(
  input  logic               clk,
  input  logic               batRstN,
  input  logic               sysRstN,
  input  logic [NUM_SRC-1:0] tamperIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   statusWord,
  output logic [REG_W-1:0]   ctrlWord,
  output logic [REG_W-1:0]   cfgWord,
  output logic               secIrq,
  output logic               freezeTime,
  output logic               timeWrAllow
);
  strobe_t            stb;
  logic               violation;
  logic               nonValid;
  logic               irqEn;
  logic [NUM_SRC-1:0] det;
  logic [NUM_SRC-1:0] srcEn;
  logic [REG_W-1:0]   lockWord;

  tamper_sup_ctrl ctrl_i (
    .batRstN   (batRstN),
    .sysRstN   (sysRstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrFlags   (wrData[1:0]),
    .violation (violation),
    .nonValid  (nonValid),
    .anyDet    (|det),
    .cfgLocked (lockWord[BIT_TL_HARD] | lockWord[BIT_TL_SOFT]),
    .stb       (stb)
  );

  tamper_sup_dpath dpath_i (
    .clk       (clk),
    .stb       (stb),
    .wrData    (wrData),
    .tamperIn  (tamperIn),
    .violation (violation),
    .nonValid  (nonValid),
    .det       (det),
    .srcEn     (srcEn),
    .lockWord  (lockWord),
    .irqEn     (irqEn)
  );

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_SRC; i++) statusWord[detPos(i)] = det[i];
    statusWord[BIT_NV]   = nonValid;
    statusWord[BIT_VIOL] = violation;
    cfgWord = '0;
    cfgWord[NUM_SRC-1:0] = srcEn;
  end

  assign ctrlWord    = lockWord;
  assign secIrq      = violation & irqEn;
  assign freezeTime  = violation | nonValid;
  assign timeWrAllow = !(lockWord[BIT_TC_SOFT] | lockWord[BIT_TC_HARD]);
endmodule

// File: rtl/tamper_sup_chk.sv
module tamper_sup_chk
  import tamper_sup_pkg::*;
(
  input logic               clk,
  input logic               batRstN,
  input logic               sysRstN,
  input logic [NUM_SRC-1:0] tamperIn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [REG_W-1:0]   statusWord,
  input logic [REG_W-1:0]   ctrlWord,
  input logic [REG_W-1:0]   cfgWord,
  input logic               secIrq
);
  logic arm1 = 1'b0;
  logic arm2 = 1'b0;

  always @(posedge clk) begin
    arm1 <= arm1 | !batRstN;
    arm2 <= arm1;
  end

  // R1
  assert_batrst_state_R1: assert property (@(posedge clk) disable iff (!arm1)
    !batRstN |=> (statusWord == 32'h2 && ctrlWord == '0 && cfgWord == '0));

  assert_enabled_hit_R2: assert property (@(posedge clk) disable iff (!arm2 || !batRstN)
    (|(tamperIn & cfgWord[NUM_SRC-1:0])) |=> statusWord[BIT_VIOL]);

  assert_irq_needs_viol_R4: assert property (@(posedge clk) disable iff (!arm2 || !batRstN)
    secIrq |-> statusWord[BIT_VIOL]);

  assert_failure_frozen_R5: assert property (@(posedge clk) disable iff (!arm2 || !batRstN)
    (statusWord[BIT_VIOL] && !statusWord[BIT_NV] && sysRstN && wrEn &&
     wrAddr == ADDR_STAT && tamperIn == '0) |=> $stable(statusWord));

  assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!arm2 || !batRstN)
    (wrEn && wrAddr == ADDR_CFG && (ctrlWord[BIT_TL_HARD] || ctrlWord[BIT_TL_SOFT]))
      |=> $stable(cfgWord));

  assert_hard_lock_kept_R7: assert property (@(posedge clk) disable iff (!arm2 || !batRstN)
    $past(batRstN) |-> (($past(ctrlWord) & HARD_MASK & ~ctrlWord) == '0));

  assert_viol_clear_from_nv_R9: assert property (@(posedge clk) disable iff (!arm2 || !batRstN)
    ($fell(statusWord[BIT_VIOL]) && $past(batRstN)) |-> $past(statusWord[BIT_NV]));

  assert_nv_clear_last_R10: assert property (@(posedge clk) disable iff (!arm2 || !batRstN)
    ($fell(statusWord[BIT_NV]) && $past(batRstN)) |-> !$past(statusWord[BIT_VIOL]));
endmodule

bind tamper_sup_top tamper_sup_chk chk_i (
  .clk        (clk),
  .batRstN    (batRstN),
  .sysRstN    (sysRstN),
  .tamperIn   (tamperIn),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .statusWord (statusWord),
  .ctrlWord   (ctrlWord),
  .cfgWord    (cfgWord),
  .secIrq     (secIrq)
);

// File: tb/tamper_sup_top_tb_top.sv
`timescale 1ns/1ps
module tamper_sup_top_tb_top;
  logic        clk = 1'b0;
  logic        batRstN = 1'b0;
  logic        sysRstN = 1'b1;
  logic [9:0]  tamperIn = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] statusWord, ctrlWord, cfgWord;
  logic        secIrq, freezeTime, timeWrAllow;

  int nVec = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  tamper_sup_top dut_i (
    .clk(clk), .batRstN(batRstN), .sysRstN(sysRstN), .tamperIn(tamperIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusWord(statusWord), .ctrlWord(ctrlWord), .cfgWord(cfgWord),
    .secIrq(secIrq), .freezeTime(freezeTime), .timeWrAllow(timeWrAllow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseSrc(input logic [9:0] m);
    @(negedge clk); tamperIn = m;
    @(negedge clk); tamperIn = '0;
  endtask

  task automatic pulseSys();
    @(negedge clk); sysRstN = 1'b0;
    @(negedge clk); sysRstN = 1'b1;
  endtask

  task automatic pulseBat();
    @(negedge clk); batRstN = 1'b0;
    @(negedge clk); batRstN = 1'b1;
  endtask

  task automatic t_reset();
    pulseBat();
    check("R1 status", statusWord, 32'h2);
    check("R1 ctrl", ctrlWord, 32'h0);
    check("R1 cfg", cfgWord, 32'h0);
    check("R1 irq", {31'b0, secIrq}, 32'h0);
    check("R3 freeze nv", {31'b0, freezeTime}, 32'h1);
    check("R11 allow", {31'b0, timeWrAllow}, 32'h1);
  endtask

  task automatic t_toValid();
    regWrite(2'd1, 32'h2);
    check("R10 nv clear", statusWord, 32'h0);
    check("R3 freeze valid", {31'b0, freezeTime}, 32'h0);
  endtask

  task automatic t_disabledSrc();
    pulseSrc(10'h3FF);
    check("R2 disabled ignored", statusWord, 32'h0);
  endtask

  task automatic t_failAndRecover();
    regWrite(2'd2, 32'h101);
    regWrite(2'd3, 32'h1);
    pulseSrc(10'h100);
    check("R2 time ovf", statusWord, 32'h5);
    check("R4 irq", {31'b0, secIrq}, 32'h1);
    check("R3 freeze fail", {31'b0, freezeTime}, 32'h1);
    regWrite(2'd1, 32'hFFFF_FFFF);
    check("R5 fail write ignored", statusWord, 32'h5);
    pulseSys();
    check("R5 sysrst to nv+fail", statusWord, 32'h7);
    check("R12 irq en cleared", {31'b0, secIrq}, 32'h0);
    regWrite(2'd1, 32'h1);
    check("R9 viol with detect", statusWord, 32'h7);
    regWrite(2'd1, 32'h2);
    check("R10 nv before viol", statusWord, 32'h7);
    regWrite(2'd2, 32'h0);
    regWrite(2'd1, 32'h4);
    check("R8 detect clear", statusWord, 32'h3);
    regWrite(2'd1, 32'h1);
    check("R9 viol clear", statusWord, 32'h2);
    regWrite(2'd1, 32'h2);
    check("R10 back to valid", statusWord, 32'h0);
  endtask

  task automatic t_allSources();
    regWrite(2'd2, 32'h3FF);
    pulseSrc(10'h3FF);
    check("R2 all positions", statusWord, 32'h00FF_000D);
    pulseSys();
    check("R12 sysrst keeps detect", statusWord, 32'h00FF_000F);
    regWrite(2'd2, 32'h0);
    regWrite(2'd1, 32'h00FF_000C);
    regWrite(2'd1, 32'h1);
    regWrite(2'd1, 32'h2);
    check("R9 R10 full recovery", statusWord, 32'h0);
  endtask

  task automatic t_stickyDetect();
    regWrite(2'd2, 32'h80);
    @(negedge clk); tamperIn = 10'h080;
    @(negedge clk);
    check("R2 wire-mesh", statusWord, 32'h0080_0001);
    pulseSys();
    regWrite(2'd1, 32'h0080_0000);
    check("R8 live source sticks", statusWord, 32'h0080_0003);
    @(negedge clk); tamperIn = '0;
    regWrite(2'd2, 32'h0);
    regWrite(2'd1, 32'h0080_0000);
    check("R8 cleared after release", statusWord, 32'h3);
    regWrite(2'd1, 32'h1);
    regWrite(2'd1, 32'h2);
  endtask

  task automatic t_locks();
    regWrite(2'd0, 32'h2000_0000);
    regWrite(2'd2, 32'h1);
    check("R6 soft lock refuses cfg", cfgWord, 32'h0);
    regWrite(2'd0, 32'h0002_0000);
    check("R11 timer soft lock", {31'b0, timeWrAllow}, 32'h0);
    pulseSys();
    check("R7 soft released", ctrlWord, 32'h0);
    check("R11 allow after sysrst", {31'b0, timeWrAllow}, 32'h1);
    check("R12 flags kept", statusWord, 32'h0);
    regWrite(2'd2, 32'h1);
    check("R6 cfg after release", cfgWord, 32'h1);
    regWrite(2'd0, 32'h7FFF_FFFF);
    check("R7 all locks", ctrlWord, 32'h601F_0000);
    regWrite(2'd0, 32'h0);
    check("R7 set only", ctrlWord, 32'h601F_0000);
    pulseSys();
    check("R7 hard survive sysrst", ctrlWord, 32'h4015_0000);
    check("R11 timer hard lock", {31'b0, timeWrAllow}, 32'h0);
    regWrite(2'd2, 32'h3);
    check("R6 hard lock refuses cfg", cfgWord, 32'h1);
    pulseBat();
    check("R1 hard cleared", ctrlWord, 32'h0);
    check("R1 nv again", statusWord, 32'h2);
    check("R1 cfg cleared", cfgWord, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_toValid();
    t_disabledSrc();
    t_failAndRecover();
    t_allSources();
    t_stickyDetect();
    t_locks();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule